// File: doc/BRIEF.md
# Host Receive Byte-Lane Read Port

This block hands a word from the processor side to an external host that reads 8 bits at a time. The processor offers a full 24-bit word on a load interface. When the block accepts it, the word is captured into a holding register and a receive-full flag is raised. The host then reads the word back as three read-only byte registers, chosen by a 3-bit host address. Those registers sit at addresses 5, 6 and 7. An endianness control input decides which byte lane answers at which of these addresses.

The flag is held by a two-state controller with states `S_EMPTY` and `S_FULL`:

- `T_FILL` moves it from `S_EMPTY` to `S_FULL` when a load is accepted.
- `T_DRAIN` moves it from `S_FULL` to `S_EMPTY` when the host reads address 7 and no load arrives.
- `T_REFILL` keeps it in `S_FULL` when a load arrives in the same cycle as that read. The new word is captured.
- `T_HOLD` keeps it in `S_FULL` otherwise.

A request-enable input gates the flag onto a host request output. The host can therefore wait for a request instead of polling. The processor side sees a ready signal that tells it a load will be taken.

Top module: `hrx_read_port`

## Requirements
- R1: After reset the flag is clear: `host_req` is 0, `ld_ready` is 1, and reads of addresses 5, 6 and 7 return 0.
- R2: A load with `ld_valid`=1 while the flag is clear captures `ld_word` and sets the flag at the next rising edge.
- R3: With `big_end`=1, address 7 returns bits 23:16, address 6 returns bits 15:8 and address 5 returns bits 7:0 of the held word.
- R4: With `big_end`=0, address 5 returns bits 23:16, address 6 returns bits 15:8 and address 7 returns bits 7:0 of the held word.
- R5: `host_req` equals `req_en` AND the flag, combinationally.
- R6: A sampled host read (`host_rd`=1) of address 7 with no load clears the flag at the next rising edge, whatever byte `big_end` maps there.
- R7: Host reads of addresses 5 and 6 leave the flag unchanged.
- R8: Host reads of addresses 0 to 4 return 0 and leave the flag and the held word unchanged.
- R9: While the flag is set and address 7 is not being read, `ld_ready` is 0 and a load is ignored, so the held word and the flag are kept.
- R10: A load in the same cycle as a sampled read of address 7 wins: the flag stays set and the new word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Processor offers a word |
| ld_word | input | 24 | Word offered by the processor |
| ld_ready | output | 1 | A load in this cycle will be taken |
| big_end | input | 1 | 1: high byte at address 7; 0: high byte at address 5 |
| req_en | input | 1 | Enables the host request output |
| host_addr | input | 3 | Host byte register address |
| host_rd | input | 1 | Host read strobe |
| host_data | output | 8 | Byte at `host_addr`, 0 outside addresses 5 to 7 |
| host_req | output | 1 | Host request, set while the word waits |

## Verification
If the flag state is wrong, it shows at once on `ld_ready` and on `host_req` (with `req_en` set). So a missed fill, a missed drain or a wrong priority between load and drain is visible one edge after the cycle that caused it. If the held word or the lane map is wrong, it shows the moment the host presents an address, because `host_data` is combinational. The bench reads every lane in both endianness settings. It also reads the full-flag state back after each stimulus that should leave it unchanged.

// File: rtl/hrx_pkg.sv
package hrx_pkg;
    typedef enum logic {
        S_EMPTY = 1'b0,
        S_FULL  = 1'b1
    } hrx_state_t;
endpackage

// File: rtl/hrx_lane_map.sv
module hrx_lane_map #(
    parameter int ADDR_W     = 3,
    parameter int LANES      = 3,
    parameter int ADDR_FIRST = 5,
    localparam int LANE_IW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               big_end,
    output logic               lane_hit,
    output logic               is_last,
    output logic [LANE_IW-1:0] lane_idx
);
    localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(ADDR_FIRST);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(ADDR_FIRST + LANES - 1);
    localparam logic [ADDR_W-1:0] TOP_OFS = ADDR_W'(LANES - 1);

    logic [ADDR_W-1:0] ofs;

    always_comb begin
        ofs      = host_addr - A_FIRST;
        lane_hit = (host_addr >= A_FIRST) && (host_addr <= A_LAST);
        is_last  = (host_addr == A_LAST);
        if (big_end) begin
            lane_idx = LANE_IW'(ofs);
        end else begin
            lane_idx = LANE_IW'(TOP_OFS - ofs);
        end
    end
endmodule

// File: rtl/hrx_flag_fsm.sv
module hrx_flag_fsm
    import hrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld_valid,
    input  logic rd_last,
    output logic take,
    output logic full
);
    hrx_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        take     = 1'b0;
        full     = 1'b0;
        unique case (state)
            S_EMPTY: begin
                take = ld_valid;
                if (ld_valid) begin
                    state_nx = S_FULL;             // T_FILL
                end
            end
            S_FULL: begin
                full = 1'b1;
                take = ld_valid && rd_last;
                if (rd_last && !ld_valid) begin
                    state_nx = S_EMPTY;            // T_DRAIN
                end else begin
                    state_nx = S_FULL;             // T_REFILL / T_HOLD
                end
            end
            default: state_nx = S_EMPTY;
        endcase
    end
endmodule

// File: rtl/hrx_hold.sv
module hrx_hold #(
    parameter int BYTE_W   = 8,
    parameter int LANES    = 3,
    localparam int WORD_W  = BYTE_W * LANES,
    localparam int LANE_IW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [WORD_W-1:0]  ld_word,
    input  logic               lane_hit,
    input  logic [LANE_IW-1:0] lane_idx,
    output logic [WORD_W-1:0]  word_q,
    output logic [BYTE_W-1:0]  byte_out
);
    logic [BYTE_W-1:0] lane_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (take) begin
                lane_q[g] <= ld_word[g*BYTE_W +: BYTE_W];
            end
        end
        assign word_q[g*BYTE_W +: BYTE_W] = lane_q[g];
    end

    always_comb begin
        byte_out = '0;
        if (lane_hit && (int'(lane_idx) < LANES)) begin
            byte_out = lane_q[lane_idx];
        end
    end
endmodule

// File: rtl/hrx_read_port.sv
module hrx_read_port #(
    parameter int BYTE_W     = 8,
    parameter int LANES      = 3,
    parameter int ADDR_W     = 3,
    parameter int ADDR_FIRST = 5,
    localparam int WORD_W    = BYTE_W * LANES,
    localparam int LANE_IW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [WORD_W-1:0] ld_word,
    output logic              ld_ready,
    input  logic              big_end,
    input  logic              req_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    output logic [BYTE_W-1:0] host_data,
    output logic              host_req
);
    logic               lane_hit;
    logic               is_last;
    logic [LANE_IW-1:0] lane_idx;
    logic               rd_last;
    logic               take;
    logic               full;
    logic [WORD_W-1:0]  word_q;

    hrx_lane_map #(
        .ADDR_W(ADDR_W), .LANES(LANES), .ADDR_FIRST(ADDR_FIRST)
    ) u_map (
        .host_addr(host_addr), .big_end(big_end),
        .lane_hit(lane_hit), .is_last(is_last), .lane_idx(lane_idx)
    );

    assign rd_last = host_rd && is_last;

    hrx_flag_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid),
        .rd_last(rd_last), .take(take), .full(full)
    );

    hrx_hold #(.BYTE_W(BYTE_W), .LANES(LANES)) u_hold (
        .clk(clk), .rst_n(rst_n), .take(take), .ld_word(ld_word),
        .lane_hit(lane_hit), .lane_idx(lane_idx),
        .word_q(word_q), .byte_out(host_data)
    );

    assign ld_ready = !full || rd_last;
    assign host_req = req_en && full;
endmodule

// File: rtl/hrx_read_port_chk.sv
module hrx_read_port_chk #(
    parameter int BYTE_W     = 8,
    parameter int LANES      = 3,
    parameter int ADDR_W     = 3,
    parameter int ADDR_FIRST = 5,
    localparam int WORD_W    = BYTE_W * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic [WORD_W-1:0] ld_word,
    input logic              ld_ready,
    input logic              req_en,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rd,
    input logic [BYTE_W-1:0] host_data,
    input logic              host_req,
    input logic              full,
    input logic [WORD_W-1:0] word_q
);
    localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(ADDR_FIRST);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(ADDR_FIRST + LANES - 1);

    logic rd7;
    assign rd7 = host_rd && (host_addr == A_LAST);

    p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && ld_valid) |=> (full && word_q == $past(ld_word)));

    p_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_req == (req_en && full));

    p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd7 && !ld_valid) |=> !full);

    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd7) |=> full);

    p_oob_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr < A_FIRST) |-> (host_data == '0));

    p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd7) |-> (!ld_ready ##1 $stable(word_q)));

    p_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd7 && ld_valid) |=> (full && word_q == $past(ld_word)));
endmodule

bind hrx_read_port hrx_read_port_chk #(
    .BYTE_W(BYTE_W), .LANES(LANES), .ADDR_W(ADDR_W), .ADDR_FIRST(ADDR_FIRST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_word(ld_word),
    .ld_ready(ld_ready), .req_en(req_en), .host_addr(host_addr),
    .host_rd(host_rd), .host_data(host_data), .host_req(host_req),
    .full(full), .word_q(word_q)
);

// File: tb/hrx_read_port_test.sv
`timescale 1ns/1ps
module hrx_read_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [23:0] ld_word = '0;
    logic        ld_ready;
    logic        big_end = 1'b1;
    logic        req_en = 1'b1;
    logic [2:0]  host_addr = '0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_data;
    logic        host_req;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    hrx_read_port uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_word(ld_word),
        .ld_ready(ld_ready), .big_end(big_end), .req_en(req_en),
        .host_addr(host_addr), .host_rd(host_rd), .host_data(host_data),
        .host_req(host_req)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Flag is observed through ld_ready with no read in progress.
    task automatic check_full(string req, bit exp);
        check(req, "flag (via ld_ready)", int'(!ld_ready), int'(exp));
        check(req, "host_req", int'(host_req), int'(exp && req_en));
    endtask

    // Peek without a strobe: no edge consumed.
    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_data;
        host_addr = 3'd0;
    endtask

    // Strobed read: strobe is sampled at one rising edge.
    task automatic rd(input logic [2:0] a, input bit with_load,
                      input logic [23:0] w, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        host_rd   = 1'b1;
        ld_valid  = with_load;
        ld_word   = w;
        #1 d = host_data;
        @(negedge clk);
        host_rd   = 1'b0;
        ld_valid  = 1'b0;
        host_addr = 3'd0;
        #1;
    endtask

    task automatic load(input logic [23:0] w);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_word  = w;
        @(negedge clk);
        ld_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check_full("R1", 1'b0);
        for (int a = 5; a <= 7; a++) begin
            peek(3'(a), d);
            check("R1", "byte after reset", int'(d), 0);
        end
    endtask

    task automatic t_fill;
        load(24'hA1B2C3);
        check_full("R2", 1'b1);
    endtask

    task automatic t_maps;
        logic [7:0] d;
        big_end = 1'b1;
        peek(3'd7, d); check("R3", "addr7 big", int'(d), 'hA1);
        peek(3'd6, d); check("R3", "addr6 big", int'(d), 'hB2);
        peek(3'd5, d); check("R3", "addr5 big", int'(d), 'hC3);
        big_end = 1'b0;
        peek(3'd5, d); check("R4", "addr5 little", int'(d), 'hA1);
        peek(3'd6, d); check("R4", "addr6 little", int'(d), 'hB2);
        peek(3'd7, d); check("R4", "addr7 little", int'(d), 'hC3);
        big_end = 1'b1;
    endtask

    task automatic t_req;
        @(negedge clk); req_en = 1'b0; #1;
        check("R5", "host_req gated off", int'(host_req), 0);
        @(negedge clk); req_en = 1'b1; #1;
        check("R5", "host_req enabled", int'(host_req), 1);
    endtask

    task automatic t_keep_and_oob;
        logic [7:0] d;
        rd(3'd5, 1'b0, '0, d); check("R7", "addr5 read data", int'(d), 'hC3);
        check_full("R7", 1'b1);
        rd(3'd6, 1'b0, '0, d); check("R7", "addr6 read data", int'(d), 'hB2);
        check_full("R7", 1'b1);
        for (int a = 0; a <= 4; a++) begin
            rd(3'(a), 1'b0, '0, d);
            check("R8", "out-of-range data", int'(d), 0);
        end
        check_full("R8", 1'b1);
        peek(3'd7, d); check("R8", "word kept", int'(d), 'hA1);
    endtask

    task automatic t_block;
        logic [7:0] d;
        check("R9", "ld_ready while full", int'(ld_ready), 0);
        load(24'h123456);
        check_full("R9", 1'b1);
        peek(3'd7, d); check("R9", "word kept hi", int'(d), 'hA1);
        peek(3'd5, d); check("R9", "word kept lo", int'(d), 'hC3);
    endtask

    task automatic t_drain;
        logic [7:0] d;
        big_end = 1'b1;
        rd(3'd7, 1'b0, '0, d);
        check("R6", "addr7 data big", int'(d), 'hA1);
        check_full("R6", 1'b0);
        load(24'h0F1E2D);
        big_end = 1'b0;
        rd(3'd7, 1'b0, '0, d);
        check("R6", "addr7 data little", int'(d), 'h2D);
        check_full("R6", 1'b0);
        big_end = 1'b1;
    endtask

    task automatic t_prio;
        logic [7:0] d;
        load(24'h445566);
        rd(3'd7, 1'b1, 24'h778899, d);
        check("R10", "old byte on read", int'(d), 'h44);
        check_full("R10", 1'b1);
        peek(3'd7, d); check("R10", "new hi", int'(d), 'h77);
        peek(3'd6, d); check("R10", "new mid", int'(d), 'h88);
        peek(3'd5, d); check("R10", "new lo", int'(d), 'h99);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_fill();
        t_maps();
        t_req();
        t_keep_and_oob();
        t_block();
        t_drain();
        t_prio();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule